// File: doc/BRIEF.md
# Infrared Receive Symbol Queue with Event Interrupt

This block sits between an infrared pulse sampler and a register bus. The sampler delivers one byte per captured run-length symbol. The block stores these bytes in a first-in first-out queue, and software drains the queue through a data register. Each read of that register removes one byte.

A status register shows how many bytes are waiting. It also holds three sticky event flags: queue overflow, end of packet, and a data-available condition. The data-available condition fires when the fill count rises above a programmable level. An enable register selects which flags can drive the single interrupt line. Software clears flags by writing ones to them. Software normally raises the level to half the queue, so that it is interrupted at packet end or when the queue is half full.

The queue depth is a parameter, either 16 or 64 bytes. The count field is `$clog2(DEPTH)+1` bits wide, so it can show a completely full queue. Addresses are word indices: 0 is data, 1 is enable, 2 is status. Any other address reads as zero.

Top module: `ir_rxq_top`

## Requirements
- R1: After a synchronous active-low reset, the interrupt output is low and both the enable register (address 1) and the status register (address 2) read as zero.
- R2: Bytes read from the data register (address 0) come out in the order they arrived on `sym_data` with `sym_valid` high. Each read strobe to address 0 removes exactly one byte.
- R3: The status register reports the number of stored bytes in bits starting at bit 8. The field is `$clog2(DEPTH)+1` bits wide, and the count is visible in the cycle after the push or pop edge.
- R4: A byte that arrives while the queue holds DEPTH bytes is discarded and sets status bit 0 (overflow). This holds even if a pop happens in the same cycle. The count then stays at DEPTH, less any pop.
- R5: A high cycle on `pkt_end` sets status bit 1 (packet end).
- R6: Status bit 4 (data available) sets one cycle after the count becomes greater than the level field. The level field sits in the enable register starting at bit 8 and has the same width as the count.
- R7: A write to the status register clears each of bits 0, 1 and 4 whose write-data bit is one, and leaves the others unchanged. Writing 0xFF clears all three.
- R8: When an event sets a flag in the same cycle that a status write clears it, the flag ends up set.
- R9: The interrupt output is high exactly when some status flag is set and its enable bit is set. The enable bits are bit 0 for overflow, bit 1 for packet end and bit 4 for data available. The enable register reads back as written, in those bits and in the level field.
- R10: A read of the data register while the queue is empty returns zero and does not move the queue: the count stays zero, and the next byte pushed is the next byte read.
- R11: A write to the data register has no effect on the queue contents or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | A symbol byte is presented this cycle |
| sym_data | input | 8 | Symbol byte from the sampler |
| pkt_end | input | 1 | One-cycle pulse at the end of a packet |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; at address 0 it pops a byte |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
Faults show up at the ports in different ways:
- A corrupted pointer shows up as a byte out of order, or as a nonzero read from an empty queue, on the very next data read.
- A wrong count shows up in the status count field one cycle after the push or pop edge.
- A wrong count also moves the data-available flag one cycle later, and with it the interrupt line.
- A sticky flag that clears wrongly, or ignores its enable, shows on `irq` within the same cycle that the flag changes.

The bench fills the queue to exactly DEPTH and then pushes one more byte. When it drains the queue, the last byte read must be the last byte that was accepted.

// File: rtl/ir_rxq_pkg.sv
// Package: shared constants for the infrared receive symbol queue.
// Assumes: register words are 32 bits wide and addressed by a 2-bit word index.
package ir_rxq_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 2;
    localparam int SYM_W     = 8;
    localparam int N_EVT     = 3;
    // Event indices inside the flag vector.
    localparam int EV_OVF    = 0;
    localparam int EV_PKT    = 1;
    localparam int EV_AVL    = 2;
    // Bit positions of the events in the enable and status words.
    localparam int BIT_OVF   = 0;
    localparam int BIT_PKT   = 1;
    localparam int BIT_AVL   = 4;
    localparam int FIELD_LSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA = 2'd0,
        RA_IEN  = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    // Gathers the three event bits out of a register word.
    function automatic logic [N_EVT-1:0] pick_events(input logic [REG_W-1:0] w);
        pick_events = {w[BIT_AVL], w[BIT_PKT], w[BIT_OVF]};
    endfunction

    // Places the three event bits at their positions in a register word.
    function automatic logic [REG_W-1:0] place_events(input logic [N_EVT-1:0] e);
        place_events          = '0;
        place_events[BIT_OVF] = e[EV_OVF];
        place_events[BIT_PKT] = e[EV_PKT];
        place_events[BIT_AVL] = e[EV_AVL];
    endfunction
endpackage

// File: rtl/ir_rxq_store.sv
// Module: circular byte store with read/write pointers and a fill count.
// What it does: accepts a byte when not full, pops one when not empty, and
// flags a push that arrives at a full store as dropped.
// Assumes: push and pop are single-cycle strobes; fullness is judged on the
// count before this edge, so a pop in the same cycle does not rescue a push.
module ir_rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             dropped
);
    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push && full;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Advances a pointer, wrapping at the last slot.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Writes an accepted byte into its slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Moves the pointers on accepted pushes and effective pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    // Tracks the number of stored bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: the count never exceeds the depth.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R4: a byte arriving at a full store without a pop leaves it full.
    p_drop_keeps_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CNT_W'(DEPTH)));
    // R10: popping an empty store leaves the count at zero.
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/ir_rxq_events.sv
// Module: sticky event flags with write-one-to-clear and an interrupt reduction.
// What it does: each flag sets on its event and clears on its clear bit. A set
// in the same cycle as a clear wins. The interrupt is the OR of flag AND enable.
// Assumes: set and clear vectors are one-cycle qualified strobes.
module ir_rxq_events #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] en_vec,
    output logic [N-1:0] pend,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Holds one sticky flag, with set taking precedence over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          pend[i] <= 1'b0;
            else if (set_vec[i]) pend[i] <= 1'b1;
            else if (clr_vec[i]) pend[i] <= 1'b0;
        end

        // R8: a set always lands, even against a clear.
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> pend[i]);
        // R7: a clear without a set leaves the flag low.
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !pend[i]);
    end

    assign irq = |(pend & en_vec);

    // R9: with no enables, no interrupt.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq);
    // R9: an interrupt implies some pending flag.
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));
endmodule

// File: rtl/ir_rxq_top.sv
// Module: infrared receive symbol queue with register port and interrupt.
// What it does: pushes sampler bytes into a store and decodes register reads
// and writes for data (pop), enable/level and status (count + W1C flags).
// Assumes: reg_rdata is used in the cycle the read strobe is high; the pop
// takes effect at the end of that cycle.
module ir_rxq_top
    import ir_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic [SYM_W-1:0]  sym_data,
    input  logic              pkt_end,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    reg_addr_e        addr;
    logic [SYM_W-1:0] head;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             empty;
    logic             dropped;
    logic             pop;
    logic [N_EVT-1:0] en_bits;
    logic [CNT_W-1:0] level;
    logic [N_EVT-1:0] set_vec;
    logic [N_EVT-1:0] clr_vec;
    logic [N_EVT-1:0] pend;
    logic             unused_wdata;

    assign addr         = reg_addr_e'(reg_addr);
    assign pop          = reg_rd && (addr == RA_DATA);
    assign unused_wdata = ^{full, reg_wdata};

    ir_rxq_store #(.DEPTH(DEPTH), .DW(SYM_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sym_valid),
        .push_data (sym_data),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty),
        .dropped   (dropped)
    );

    // Holds the enable bits and the data-available level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bits <= '0;
            level   <= '0;
        end else if (reg_wr && addr == RA_IEN) begin
            en_bits <= pick_events(reg_wdata);
            level   <= reg_wdata[FIELD_LSB +: CNT_W];
        end
    end

    // Forms the per-event set and clear strobes.
    always_comb begin
        set_vec         = '0;
        set_vec[EV_OVF] = dropped;
        set_vec[EV_PKT] = pkt_end;
        set_vec[EV_AVL] = (count > level);
        clr_vec = (reg_wr && addr == RA_STAT) ? pick_events(reg_wdata) : '0;
    end

    ir_rxq_events #(.N(N_EVT)) u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (en_bits),
        .pend    (pend),
        .irq     (irq)
    );

    // Selects the word presented on the read port.
    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_DATA: reg_rdata[SYM_W-1:0] = empty ? '0 : head;
            RA_IEN: begin
                reg_rdata = place_events(en_bits);
                reg_rdata[FIELD_LSB +: CNT_W] = level;
            end
            RA_STAT: begin
                reg_rdata = place_events(pend);
                reg_rdata[FIELD_LSB +: CNT_W] = count;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R6: the count above the level raises the available flag next cycle.
    p_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count > level) |=> pend[EV_AVL]);
    // R5: a packet-end pulse raises its flag.
    p_pkt_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> pend[EV_PKT]);
    // R11: a write to the data address alone does not move the count.
    p_data_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && addr == RA_DATA && !sym_valid && !reg_rd) |=> $stable(count));
    // R10: an empty data read returns zero.
    p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |-> (reg_rdata == '0));
endmodule

// File: tb/test_ir_rxq_top.sv
// Directed bench for the infrared receive symbol queue.
module test_ir_rxq_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [7:0]  sym_data = '0;
    logic        pkt_end = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ir_rxq_top #(.DEPTH(DEPTH)) i_ir_rxq_top (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
        .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        sym_valid = 1'b1; sym_data = b;
        tick;
        sym_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        tick;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick;
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] cnt_of(input logic [31:0] st);
        cnt_of = (st >> 8) & 32'h1F;
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd2, v); check("R1 status", v, 32'h0);
        rd(2'd1, v); check("R1 enable", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_order;
        logic [31:0] v;
        push(8'hA1); push(8'hB2); push(8'hC3);
        rd(2'd2, v); check("R3 count 3", cnt_of(v), 32'd3);
        rd(2'd0, v); check("R2 byte0", v, 32'hA1);
        rd(2'd0, v); check("R2 byte1", v, 32'hB2);
        rd(2'd0, v); check("R2 byte2", v, 32'hC3);
        rd(2'd2, v); check("R3 count 0", cnt_of(v), 32'd0);
    endtask

    task automatic t_empty;
        logic [31:0] v;
        rd(2'd0, v); check("R10 empty read", v, 32'h0);
        rd(2'd2, v); check("R10 count stays", cnt_of(v), 32'd0);
        push(8'h55);
        rd(2'd0, v); check("R10 next byte", v, 32'h55);
    endtask

    task automatic t_data_write;
        logic [31:0] v;
        wr(2'd0, 32'h77);
        rd(2'd2, v); check("R11 count", cnt_of(v), 32'd0);
        rd(2'd0, v); check("R11 still empty", v, 32'h0);
    endtask

    task automatic t_pkt;
        logic [31:0] v;
        wr(2'd2, 32'hFF);
        pkt_end = 1'b1; tick; pkt_end = 1'b0;
        rd(2'd2, v); check("R5 pkt flag", v & 32'h13, 32'h02);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h2);
        check("R9 irq on", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h11);
        rd(2'd2, v); check("R7 zero bit keeps", v & 32'h02, 32'h02);
        wr(2'd2, 32'h02);
        rd(2'd2, v); check("R7 clear pkt", v & 32'h02, 32'h0);
        check("R9 irq off", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        wr(2'd1, 32'h0000_0210);
        rd(2'd1, v); check("R9 enable readback", v, 32'h0000_0210);
        wr(2'd2, 32'hFF);
        push(8'h01); push(8'h02); tick;
        rd(2'd2, v); check("R6 at level", v & 32'h10, 32'h0);
        check("R6 irq low", {31'b0, irq}, 32'h0);
        push(8'h03);
        rd(2'd2, v); check("R6 not yet", v & 32'h10, 32'h0);
        tick;
        rd(2'd2, v); check("R6 above level", v & 32'h10, 32'h10);
        check("R9 irq avail", {31'b0, irq}, 32'h1);
        rd(2'd0, v); tick;
        wr(2'd2, 32'h10); tick;
        rd(2'd2, v); check("R7 avail cleared", v & 32'h10, 32'h0);
        rd(2'd0, v); rd(2'd0, v);
        check("R2 drain", v, 32'h03);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        wr(2'd1, 32'h1);
        wr(2'd2, 32'hFF);
        for (int i = 0; i < DEPTH; i++) push(8'h10 + 8'(i));
        rd(2'd2, v); check("R3 full count", cnt_of(v), 32'(DEPTH));
        check("R4 no ovf yet", v & 32'h1, 32'h0);
        push(8'hEE);
        rd(2'd2, v); check("R4 ovf flag", v & 32'h1, 32'h1);
        check("R4 count held", cnt_of(v), 32'(DEPTH));
        check("R9 irq ovf", {31'b0, irq}, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            rd(2'd0, v);
            check("R4 drained byte", v, 32'h10 + 32'(i));
        end
        rd(2'd0, v); check("R4 dropped gone", v, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        wr(2'd1, 32'h0);
        pkt_end = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hFF;
        tick;
        pkt_end = 1'b0; reg_wr = 1'b0;
        rd(2'd2, v); check("R8 set wins", v & 32'h13, 32'h02);
        wr(2'd2, 32'hFF);
        rd(2'd2, v); check("R7 all clear", v & 32'hFF, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_order;
        t_empty;
        t_data_write;
        t_pkt;
        t_level;
        t_overflow;
        t_set_wins;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule